// File: doc/BRIEF.md
# Decode-Stage Instruction Decoder with Branch Resolution

This block sits in the decode stage of a 16-bit pipelined processor. Each accepted 16-bit instruction word is split into a 4-bit opcode and three 4-bit fields. The block turns it into register indices, an extended immediate, an ALU operation code, a shift kind, memory read and write strobes, and up to two register-write ports. It also resolves the two compare-and-branch instructions in the same stage, using the operand values that the register file supplies alongside the instruction. It produces a taken flag and a PC-relative target.

The register conventions are fixed in the block. Index 0 always reads as zero and index 1 always reads as one, whatever the register file returns. Index 13 is the link register, index 14 receives comparison status, and index 15 is the program counter. Writes aimed at the two constant registers are dropped. Reserved opcodes decode to a no-op and raise an illegal-instruction flag. All results are registered, so they appear one clock after the instruction is presented with `in_valid` high.

Top module: `idec_top`

## Requirements
- R1: For opcodes 0000 to 0110, `alu_op` equals the opcode (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 divide/modulo, 6 multiply), `src_a_idx` = bits [7:4], `src_b_idx` = bits [3:0], `wr_idx` = bits [11:8] with `wr_en` high, and `imm` = 0.
- R2: Opcode 0101 also raises `wr2_en`, with `wr2_idx` = bits [3:0], so that the remainder goes back into the second source register.
- R3: Opcode 0111 (compare) gives `alu_op` = 7, `src_a_idx` = bits [11:8], `src_b_idx` = bits [7:4] and `wr_idx` = 14 with `wr_en` high. Bits [3:0] are unused.
- R4: Opcode 1000 (shift/rotate) gives `alu_op` = 8 and `shift_kind` = bits [3:2] (0 shift left, 1 shift right, 2 rotate left, 3 rotate right). The amount register `src_b_idx` = bits [7:4], and both `src_a_idx` and `wr_idx` = bits [11:8].
- R5: Opcode 1001 (load) raises `mem_rd` with `alu_op` = 0 and `src_a_idx` = bits [7:4]. It sets `imm` to bits [3:0] zero-extended and `wr_idx` = bits [11:8] with `wr_en` high. `mem_rd` and `mem_wr` are never both high.
- R6: Opcode 1010 (store) raises `mem_wr` with `alu_op` = 0, `src_a_idx` = bits [7:4] and `src_b_idx` = bits [11:8] (the data register). It sets `imm` to bits [3:0] zero-extended, and `wr_en` stays low.
- R7: Opcode 1011 raises `is_branch`. `br_taken` is high when the effective value of register bits [11:8] equals that of bits [7:4]. `br_target` = `pc_val` + bits [3:0] sign-extended, whether or not the branch is taken.
- R8: Opcode 1111 behaves like R7, but `br_taken` is high when the bits [11:8] value is less than the bits [7:4] value as signed 16-bit numbers.
- R9: In branch resolution, a field of 0 compares as value 0 and a field of 1 compares as value 1, ignoring `opnd_d_val` / `opnd_a_val`.
- R10: Any write whose index is 0 or 1 has its enable (`wr_en` or `wr2_en`) forced low. Other controls, such as `mem_rd`, are unaffected.
- R11: Opcodes 1100, 1101 and 1110 set `illegal` and `alu_op` = 15, with every write, memory and branch strobe low.
- R12: Outputs are registered. An instruction presented with `in_valid` high appears on the outputs after the next rising edge with `out_valid` high. A cycle with `in_valid` low yields `out_valid` low and all controls zero, and so does reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| opnd_d_val | input | 16 | Register-file value for index bits [11:8] |
| opnd_a_val | input | 16 | Register-file value for index bits [7:4] |
| pc_val | input | 16 | Program counter of this instruction |
| out_valid | output | 1 | Decoded result valid |
| alu_op | output | 4 | ALU operation code |
| shift_kind | output | 2 | Shift/rotate kind |
| src_a_idx | output | 4 | First source register index |
| src_b_idx | output | 4 | Second source register index |
| wr_en | output | 1 | Primary register write enable |
| wr_idx | output | 4 | Primary destination index |
| wr2_en | output | 1 | Secondary register write enable |
| wr2_idx | output | 4 | Secondary destination index |
| imm | output | 16 | Extended immediate |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| is_branch | output | 1 | Instruction is a conditional branch |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | 16 | Branch target address |
| illegal | output | 1 | Reserved opcode seen |

## Verification
Several properties are checked on every cycle:
- No write enable ever targets index 0 or 1.
- A reserved opcode leaves every strobe quiet.
- Load and store strobes are never both high.
- A taken branch is always a branch.
- The target always equals the previous cycle's PC plus the immediate.
- An idle cycle produces a quiet output.

Only the directed scenarios can show that each opcode gets the right field mapping and extension. They also cover signed versus unsigned comparison at the sign boundary and the override of the constant registers during comparison.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int ILEN = 16;
    localparam int FW   = 4;
    localparam int XLEN = 16;

    typedef enum logic [3:0] {
        OPC_ADD    = 4'd0,
        OPC_SUB    = 4'd1,
        OPC_AND    = 4'd2,
        OPC_OR     = 4'd3,
        OPC_XOR    = 4'd4,
        OPC_DIVMOD = 4'd5,
        OPC_MUL    = 4'd6,
        OPC_CMP    = 4'd7,
        OPC_SHF    = 4'd8,
        OPC_LOAD   = 4'd9,
        OPC_STORE  = 4'd10,
        OPC_BEQ    = 4'd11,
        OPC_RSV0   = 4'd12,
        OPC_RSV1   = 4'd13,
        OPC_RSV2   = 4'd14,
        OPC_BLT    = 4'd15
    } opc_e;

    typedef enum logic [3:0] {
        ALU_ADD    = 4'd0,
        ALU_SUB    = 4'd1,
        ALU_AND    = 4'd2,
        ALU_OR     = 4'd3,
        ALU_XOR    = 4'd4,
        ALU_DIVMOD = 4'd5,
        ALU_MUL    = 4'd6,
        ALU_CMP    = 4'd7,
        ALU_SHF    = 4'd8,
        ALU_NONE   = 4'd15
    } alu_e;

    localparam logic [FW-1:0] REG_ZERO = 4'd0;
    localparam logic [FW-1:0] REG_ONE  = 4'd1;
    localparam logic [FW-1:0] REG_LINK = 4'd13;
    localparam logic [FW-1:0] REG_STAT = 4'd14;
    localparam logic [FW-1:0] REG_PC   = 4'd15;

    typedef struct packed {
        logic [3:0]      alu_op;
        logic [1:0]      shift_kind;
        logic [FW-1:0]   src_a;
        logic [FW-1:0]   src_b;
        logic            wr_en;
        logic [FW-1:0]   wr_idx;
        logic            wr2_en;
        logic [FW-1:0]   wr2_idx;
        logic [XLEN-1:0] imm;
        logic            mem_rd;
        logic            mem_wr;
        logic            is_beq;
        logic            is_blt;
        logic            illegal;
    } dec_t;

    function automatic logic idx_is_const(input logic [FW-1:0] idx);
        return (idx == REG_ZERO) || (idx == REG_ONE);
    endfunction

endpackage

// File: rtl/idec_opnd_fix.sv
module idec_opnd_fix #(
    parameter int XLEN = 16,
    parameter int FW   = 4
) (
    input  logic [FW-1:0]   idx,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] eff
);
    localparam logic [XLEN-1:0] VAL_ONE = XLEN'(1);

    always_comb begin
        if (idx == FW'(0))
            eff = '0;
        else if (idx == FW'(1))
            eff = VAL_ONE;
        else
            eff = raw;
    end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    localparam int OPC_LSB = ILEN - FW;
    localparam int FD_LSB  = ILEN - 2*FW;
    localparam int FA_LSB  = ILEN - 3*FW;

    logic [FW-1:0]   f_d, f_a, f_b;
    logic [XLEN-1:0] imm_z, imm_s;
    opc_e            opc;
    dec_t            raw;

    assign opc   = opc_e'(instr[OPC_LSB +: FW]);
    assign f_d   = instr[FD_LSB +: FW];
    assign f_a   = instr[FA_LSB +: FW];
    assign f_b   = instr[0 +: FW];
    assign imm_z = {{(XLEN-FW){1'b0}}, f_b};
    assign imm_s = {{(XLEN-FW){f_b[FW-1]}}, f_b};

    always_comb begin
        raw = '0;
        unique case (opc)
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR, OPC_MUL: begin
                raw.alu_op = 4'(opc);
                raw.src_a  = f_a;
                raw.src_b  = f_b;
                raw.wr_en  = 1'b1;
                raw.wr_idx = f_d;
            end
            OPC_DIVMOD: begin
                raw.alu_op  = ALU_DIVMOD;
                raw.src_a   = f_a;
                raw.src_b   = f_b;
                raw.wr_en   = 1'b1;
                raw.wr_idx  = f_d;
                raw.wr2_en  = 1'b1;
                raw.wr2_idx = f_b;
            end
            OPC_CMP: begin
                raw.alu_op = ALU_CMP;
                raw.src_a  = f_d;
                raw.src_b  = f_a;
                raw.wr_en  = 1'b1;
                raw.wr_idx = REG_STAT;
            end
            OPC_SHF: begin
                raw.alu_op     = ALU_SHF;
                raw.shift_kind = f_b[FW-1 -: 2];
                raw.src_a      = f_d;
                raw.src_b      = f_a;
                raw.wr_en      = 1'b1;
                raw.wr_idx     = f_d;
            end
            OPC_LOAD: begin
                raw.alu_op = ALU_ADD;
                raw.src_a  = f_a;
                raw.imm    = imm_z;
                raw.mem_rd = 1'b1;
                raw.wr_en  = 1'b1;
                raw.wr_idx = f_d;
            end
            OPC_STORE: begin
                raw.alu_op = ALU_ADD;
                raw.src_a  = f_a;
                raw.src_b  = f_d;
                raw.imm    = imm_z;
                raw.mem_wr = 1'b1;
            end
            OPC_BEQ: begin
                raw.alu_op = ALU_NONE;
                raw.src_a  = f_d;
                raw.src_b  = f_a;
                raw.imm    = imm_s;
                raw.is_beq = 1'b1;
            end
            OPC_BLT: begin
                raw.alu_op = ALU_NONE;
                raw.src_a  = f_d;
                raw.src_b  = f_a;
                raw.imm    = imm_s;
                raw.is_blt = 1'b1;
            end
            OPC_RSV0, OPC_RSV1, OPC_RSV2: begin
                raw.alu_op  = ALU_NONE;
                raw.illegal = 1'b1;
            end
        endcase
    end

    always_comb begin
        dec = raw;
        if (idx_is_const(raw.wr_idx))
            dec.wr_en = 1'b0;
        if (idx_is_const(raw.wr2_idx))
            dec.wr2_en = 1'b0;
    end
endmodule

// File: rtl/idec_branch.sv
module idec_branch #(
    parameter int XLEN = 16
) (
    input  logic            is_beq,
    input  logic            is_blt,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic            taken,
    output logic [XLEN-1:0] target
);
    logic eq_hit, lt_hit;

    assign eq_hit = (lhs == rhs);
    assign lt_hit = ($signed(lhs) < $signed(rhs));

    always_comb begin
        taken  = (is_beq && eq_hit) || (is_blt && lt_hit);
        target = (is_beq || is_blt) ? (pc + offset) : '0;
    end
endmodule

// File: rtl/idec_top.sv
module idec_top
    import idec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [15:0]     instr,
    input  logic [15:0]     opnd_d_val,
    input  logic [15:0]     opnd_a_val,
    input  logic [15:0]     pc_val,
    output logic            out_valid,
    output logic [3:0]      alu_op,
    output logic [1:0]      shift_kind,
    output logic [3:0]      src_a_idx,
    output logic [3:0]      src_b_idx,
    output logic            wr_en,
    output logic [3:0]      wr_idx,
    output logic            wr2_en,
    output logic [3:0]      wr2_idx,
    output logic [15:0]     imm,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            is_branch,
    output logic            br_taken,
    output logic [15:0]     br_target,
    output logic            illegal
);
    localparam int NPORT  = 2;
    localparam int FD_LSB = ILEN - 2*FW;
    localparam int FA_LSB = ILEN - 3*FW;

    dec_t            dec_c, dec_q;
    logic [XLEN-1:0] raw_val [NPORT];
    logic [XLEN-1:0] eff_val [NPORT];
    logic [FW-1:0]   port_idx [NPORT];
    logic            taken_c, taken_q;
    logic [XLEN-1:0] target_c, target_q;
    logic            valid_q;

    assign raw_val[0]  = opnd_d_val;
    assign raw_val[1]  = opnd_a_val;
    assign port_idx[0] = instr[FD_LSB +: FW];
    assign port_idx[1] = instr[FA_LSB +: FW];

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_opnd
            idec_opnd_fix #(.XLEN(XLEN), .FW(FW)) u_fix (
                .idx (port_idx[p]),
                .raw (raw_val[p]),
                .eff (eff_val[p])
            );
        end
    endgenerate

    idec_ctrl u_ctrl (
        .instr (instr),
        .dec   (dec_c)
    );

    idec_branch #(.XLEN(XLEN)) u_br (
        .is_beq (dec_c.is_beq),
        .is_blt (dec_c.is_blt),
        .lhs    (eff_val[0]),
        .rhs    (eff_val[1]),
        .pc     (pc_val),
        .offset (dec_c.imm),
        .taken  (taken_c),
        .target (target_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            valid_q  <= 1'b0;
            dec_q    <= '0;
            taken_q  <= 1'b0;
            target_q <= '0;
        end else begin
            valid_q  <= 1'b1;
            dec_q    <= dec_c;
            taken_q  <= taken_c;
            target_q <= target_c;
        end
    end

    always_comb begin
        out_valid  = valid_q;
        alu_op     = dec_q.alu_op;
        shift_kind = dec_q.shift_kind;
        src_a_idx  = dec_q.src_a;
        src_b_idx  = dec_q.src_b;
        wr_en      = dec_q.wr_en;
        wr_idx     = dec_q.wr_idx;
        wr2_en     = dec_q.wr2_en;
        wr2_idx    = dec_q.wr2_idx;
        imm        = dec_q.imm;
        mem_rd     = dec_q.mem_rd;
        mem_wr     = dec_q.mem_wr;
        is_branch  = dec_q.is_beq | dec_q.is_blt;
        br_taken   = taken_q;
        br_target  = target_q;
        illegal    = dec_q.illegal;
    end

    AST_NO_CONST_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx > 4'd1)); // R10
    AST_NO_CONST_WR2: assert property (@(posedge clk) disable iff (!rst_n)
        wr2_en |-> (wr2_idx > 4'd1)); // R10
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(wr_en || wr2_en || mem_rd || mem_wr || is_branch || br_taken)); // R11
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R5
    AST_TAKEN_IS_BR: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> is_branch); // R7
    AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (instr[15:12] == 4'd11 || instr[15:12] == 4'd15)
        |=> br_target == ($past(pc_val) + imm)); // R7
    AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(wr_en || wr2_en || mem_rd || mem_wr || br_taken || illegal)); // R12
endmodule

// File: tb/idec_top_tb.sv
module idec_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] opnd_d_val = '0;
    logic [15:0] opnd_a_val = '0;
    logic [15:0] pc_val = '0;
    logic        out_valid, wr_en, wr2_en, mem_rd, mem_wr, is_branch, br_taken, illegal;
    logic [3:0]  alu_op, src_a_idx, src_b_idx, wr_idx, wr2_idx;
    logic [1:0]  shift_kind;
    logic [15:0] imm, br_target;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    idec_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opnd_d_val(opnd_d_val), .opnd_a_val(opnd_a_val), .pc_val(pc_val),
        .out_valid(out_valid), .alu_op(alu_op), .shift_kind(shift_kind),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr2_en(wr2_en), .wr2_idx(wr2_idx), .imm(imm), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .is_branch(is_branch), .br_taken(br_taken), .br_target(br_target), .illegal(illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [3:0] d,
                                       input logic [3:0] a, input logic [3:0] b);
        return {op, d, a, b};
    endfunction

    task automatic issue(input logic [15:0] w, input logic [15:0] dv,
                         input logic [15:0] av, input logic [15:0] pc);
        @(negedge clk);
        instr = w; opnd_d_val = dv; opnd_a_val = av; pc_val = pc; in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R12", "reset out_valid", out_valid, 0);
        check("R12", "reset wr_en", wr_en, 0);
        check("R12", "reset br_taken", br_taken, 0);
    endtask

    task automatic t_rtype();
        issue(mk(4'd0, 4'd3, 4'd4, 4'd5), 0, 0, 0);
        check("R12", "valid", out_valid, 1);
        check("R1", "add alu", alu_op, 0);
        check("R1", "add src_a", src_a_idx, 4);
        check("R1", "add src_b", src_b_idx, 5);
        check("R1", "add wr", {wr_en, wr_idx}, {1'b1, 4'd3});
        check("R1", "add imm", imm, 0);
        issue(mk(4'd4, 4'd12, 4'd2, 4'd9), 0, 0, 0);
        check("R1", "xor alu", alu_op, 4);
        check("R1", "xor wr", {wr_en, wr_idx}, {1'b1, 4'd12});
        check("R1", "xor no wr2", wr2_en, 0);
    endtask

    task automatic t_divmod();
        issue(mk(4'd5, 4'd2, 4'd3, 4'd4), 0, 0, 0);
        check("R2", "divmod alu", alu_op, 5);
        check("R2", "divmod wr", {wr_en, wr_idx}, {1'b1, 4'd2});
        check("R2", "divmod wr2", {wr2_en, wr2_idx}, {1'b1, 4'd4});
        issue(mk(4'd5, 4'd2, 4'd3, 4'd1), 0, 0, 0);
        check("R10", "divmod wr2 to R1 dropped", wr2_en, 0);
        check("R10", "divmod wr kept", wr_en, 1);
    endtask

    task automatic t_cmp();
        issue(mk(4'd7, 4'd5, 4'd6, 4'd9), 0, 0, 0);
        check("R3", "cmp alu", alu_op, 7);
        check("R3", "cmp srcs", {src_a_idx, src_b_idx}, {4'd5, 4'd6});
        check("R3", "cmp wr status", {wr_en, wr_idx}, {1'b1, 4'd14});
    endtask

    task automatic t_shift();
        for (int k = 0; k < 4; k++) begin
            issue({4'd8, 4'd7, 4'd8, 2'(k), 2'b00}, 0, 0, 0);
            check("R4", "shift kind", shift_kind, k);
            check("R4", "shift alu", alu_op, 8);
            check("R4", "shift idx", {src_a_idx, src_b_idx, wr_idx}, {4'd7, 4'd8, 4'd7});
            check("R4", "shift wr_en", wr_en, 1);
        end
    endtask

    task automatic t_load();
        issue(mk(4'd9, 4'd2, 4'd3, 4'hF), 0, 0, 0);
        check("R5", "load mem", {mem_rd, mem_wr}, 2'b10);
        check("R5", "load imm zext", imm, 16'h000F);
        check("R5", "load alu/src", {alu_op, src_a_idx}, {4'd0, 4'd3});
        check("R5", "load wr", {wr_en, wr_idx}, {1'b1, 4'd2});
    endtask

    task automatic t_store();
        issue(mk(4'd10, 4'd5, 4'd6, 4'd9), 0, 0, 0);
        check("R6", "store mem", {mem_rd, mem_wr}, 2'b01);
        check("R6", "store srcs", {src_a_idx, src_b_idx}, {4'd6, 4'd5});
        check("R6", "store imm", imm, 16'h0009);
        check("R6", "store no wr", wr_en, 0);
    endtask

    task automatic t_beq();
        issue(mk(4'd11, 4'd4, 4'd5, 4'hE), 16'h1234, 16'h1234, 16'h0100);
        check("R7", "beq equal taken", {is_branch, br_taken}, 2'b11);
        check("R7", "beq target", br_target, 16'h00FE);
        check("R7", "beq imm sext", imm, 16'hFFFE);
        issue(mk(4'd11, 4'd4, 4'd5, 4'hE), 16'h1234, 16'h1235, 16'h0100);
        check("R7", "beq unequal not taken", {is_branch, br_taken}, 2'b10);
        check("R7", "beq target still", br_target, 16'h00FE);
    endtask

    task automatic t_blt();
        issue(mk(4'd15, 4'd6, 4'd7, 4'd7), 16'hFFFF, 16'h0001, 16'h0010);
        check("R8", "blt -1<1 taken", br_taken, 1);
        check("R8", "blt target", br_target, 16'h0017);
        issue(mk(4'd15, 4'd6, 4'd7, 4'd7), 16'h0001, 16'hFFFF, 16'h0010);
        check("R8", "blt 1<-1 not taken", br_taken, 0);
        issue(mk(4'd15, 4'd6, 4'd7, 4'd0), 16'h0005, 16'h0005, 16'h0010);
        check("R8", "blt equal not taken", br_taken, 0);
    endtask

    task automatic t_const_read();
        issue(mk(4'd11, 4'd0, 4'd1, 4'd2), 16'h0005, 16'h0005, 16'h0020);
        check("R9", "beq R0,R1 not taken", br_taken, 0);
        issue(mk(4'd15, 4'd0, 4'd1, 4'd2), 16'h0009, 16'h0000, 16'h0020);
        check("R9", "blt R0<R1 taken", br_taken, 1);
        issue(mk(4'd11, 4'd0, 4'd0, 4'd2), 16'h0003, 16'h0007, 16'h0020);
        check("R9", "beq R0,R0 taken", br_taken, 1);
    endtask

    task automatic t_no_const_wr();
        issue(mk(4'd0, 4'd0, 4'd4, 4'd5), 0, 0, 0);
        check("R10", "add to R0 dropped", wr_en, 0);
        issue(mk(4'd9, 4'd1, 4'd3, 4'd2), 0, 0, 0);
        check("R10", "load to R1 dropped", wr_en, 0);
        check("R10", "load to R1 still reads", mem_rd, 1);
    endtask

    task automatic t_illegal();
        for (int k = 12; k <= 14; k++) begin
            issue(mk(4'(k), 4'd3, 4'd3, 4'd3), 16'h0001, 16'h0001, 16'h0040);
            check("R11", "rsv illegal", illegal, 1);
            check("R11", "rsv alu", alu_op, 15);
            check("R11", "rsv strobes",
                  {wr_en, wr2_en, mem_rd, mem_wr, is_branch, br_taken}, 0);
        end
    endtask

    task automatic t_bubble();
        issue(mk(4'd9, 4'd2, 4'd3, 4'd1), 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R12", "bubble out_valid", out_valid, 0);
        check("R12", "bubble strobes", {wr_en, mem_rd, mem_wr, illegal}, 0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_rtype();
        t_divmod();
        t_cmp();
        t_shift();
        t_load();
        t_store();
        t_beq();
        t_blt();
        t_const_read();
        t_no_const_wr();
        t_illegal();
        t_bubble();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule